// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a 32-bit processor core that retires one instruction on every clock edge. It executes a small load/store instruction set of ten operations. These are five register-to-register arithmetic and logic operations, a signed-style set-on-less-than, a word load, a word store, a branch on equality, and an absolute jump. Every instruction is decoded from fixed bit fields. The core reads its operands, computes, accesses memory and picks the next program counter within the same cycle. Register and memory updates land on the following rising edge.

The core has two memory ports, one for instructions and one for data. Both carry byte addresses, and the word index is address bits [31:2]. Both expect a combinational read, and the data port writes on the clock edge while the write strobe is high. The ALU operation is chosen in two steps. The main decoder gives a 2-bit class code: 00 for memory access, which forces add; 01 for the branch, which forces subtract; and 10 for register operations. For the register-operation class, a second decoder refines the code from the function field. The ALU operation codes are 000 AND, 001 OR, 010 add, 011 XOR, 110 subtract and 111 set-on-less-than.

Instruction fields are as follows. The opcode is bits [31:26]. The sources are [25:21] (A) and [20:16] (B). The R-type destination is [15:11]. The function code is [5:0], the immediate is [15:0], and the jump index is [25:0]. The opcodes are 0x00 R-type, 0x23 load, 0x2B store, 0x04 branch-equal and 0x02 jump. The function codes are 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x26 xor and 0x2A slt.

Top module: `sc_core`

## Requirements
- R1: While rst_n is low, imem_addr is 0 and all 31 writable registers hold 0. Once rst_n is released, the first instruction executes from address 0 and reads 0 from every register.
- R2: An R-type instruction with function 0x20, 0x22, 0x24, 0x25 or 0x26 writes A+B, A-B, A&B, A|B or A^B respectively into the register named by bits [15:11].
- R3: An R-type instruction with function 0x2A writes to the destination the sign bit of the 32-bit difference A-B, placed in bit 0 with all other bits zero. The sign bit of the wrapped difference is used even when the subtraction overflows.
- R4: A load (opcode 0x23) drives dmem_addr with A plus the sign-extended immediate and raises dmem_re. It writes dmem_rdata into the register named by bits [20:16].
- R5: A store (opcode 0x2B) drives dmem_addr with A plus the sign-extended immediate and dmem_wdata with B. It raises dmem_we, keeps dmem_re low and writes no register.
- R6: A branch-equal (opcode 0x04) whose two sources are equal sets the next PC to PC+4 plus the sign-extended immediate shifted left by 2. When the sources differ, and for every instruction other than a jump, the next PC is PC+4.
- R7: A jump (opcode 0x02) sets the next PC to bits [31:28] of PC+4, followed by instruction bits [25:0], followed by two zero bits. The PC stays word aligned.
- R8: Register 0 always reads as 0, and a write aimed at it is discarded.
- R9: An unknown opcode, or an R-type instruction with an unknown function code, writes no register and no memory, and the PC advances by 4.
- R10: dmem_we is high only during a store instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, to be released synchronously to clk |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word read combinationally at imem_addr |
| dmem_re | output | 1 | High while a load is executing |
| dmem_we | output | 1 | Write strobe; the word is stored on the next rising edge |
| dmem_addr | output | 32 | Byte address for data access, taken from the ALU result |
| dmem_wdata | output | 32 | Store data, taken from source register B |
| dmem_rdata | input | 32 | Data word read combinationally at dmem_addr |

## Verification
The assertions take three things for granted about the inputs. They assume the instruction port returns, within the same cycle, a word that depends only on imem_addr. They assume that rst_n leaves its low level only between clock edges. They also assume that any address sequence the program produces stays word aligned, which holds as long as the PC starts at 0. The stimulus keeps within these limits in three ways. Both memories are modelled as combinational arrays indexed by address bits [7:2]. Reset is released on a falling edge. The program is built from encoded instructions whose branch offsets and jump indices point at word slots inside that array.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam int XLEN = 32;
  localparam int REG_COUNT = 32;
  localparam int REG_IDX_W = $clog2(REG_COUNT);

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_XOR = 3'b011,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_BR  = 2'b01,
    CLS_FN  = 2'b10,
    CLS_RSV = 2'b11
  } alu_cls_e;

  typedef struct packed {
    logic     dst_is_rd;
    logic     b_is_imm;
    logic     wb_from_mem;
    logic     reg_we;
    logic     mem_re;
    logic     mem_we;
    logic     is_branch;
    logic     is_jump;
    alu_cls_e alu_cls;
  } ctrl_t;

endpackage

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_op_e      op,
  output logic [W-1:0] result,
  output logic         is_zero
);

  logic [W-1:0] diff;

  always_comb begin
    diff = opa - opb;
    unique case (op)
      ALU_AND: result = opa & opb;
      ALU_OR:  result = opa | opb;
      ALU_ADD: result = opa + opb;
      ALU_XOR: result = opa ^ opb;
      ALU_SUB: result = diff;
      ALU_SLT: result = {{(W-1){1'b0}}, diff[W-1]};
      default: result = opa + opb;
    endcase
  end

  assign is_zero = (result == '0);

endmodule

// File: rtl/sc_regbank.sv
module sc_regbank #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_idx_a,
  input  logic [AW-1:0] rd_idx_b,
  output logic [W-1:0]  rd_data_a,
  output logic [W-1:0]  rd_data_b
);

  logic [W-1:0] bank_q [N];
  logic [N-1:0] slot_en;

  // Per-slot clock enables; slot 0 never enabled.
  always_comb begin
    slot_en = '0;
    for (int i = 1; i < N; i++) begin
      slot_en[i] = wr_en && (wr_idx == AW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) bank_q[i] <= '0;
    end else begin
      for (int i = 1; i < N; i++) begin
        if (slot_en[i]) bank_q[i] <= wr_data;
      end
    end
  end

  assign rd_data_a = (rd_idx_a == '0) ? '0 : bank_q[rd_idx_a];
  assign rd_data_b = (rd_idx_b == '0) ? '0 : bank_q[rd_idx_b];

endmodule

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_core_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctl
);

  always_comb begin
    ctl = '0;
    ctl.alu_cls = CLS_MEM;
    unique case (opcode)
      OPC_RTYPE: begin
        ctl.dst_is_rd = 1'b1;
        ctl.reg_we    = 1'b1;
        ctl.alu_cls   = CLS_FN;
      end
      OPC_LOAD: begin
        ctl.b_is_imm    = 1'b1;
        ctl.wb_from_mem = 1'b1;
        ctl.reg_we      = 1'b1;
        ctl.mem_re      = 1'b1;
      end
      OPC_STORE: begin
        ctl.b_is_imm = 1'b1;
        ctl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctl.is_branch = 1'b1;
        ctl.alu_cls   = CLS_BR;
      end
      OPC_JUMP: begin
        ctl.is_jump = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_core_pkg::*;
(
  input  alu_cls_e   cls,
  input  logic [5:0] funct,
  output alu_op_e    op,
  output logic       fn_known
);

  always_comb begin
    op       = ALU_ADD;
    fn_known = 1'b1;
    unique case (cls)
      CLS_MEM: op = ALU_ADD;
      CLS_BR:  op = ALU_SUB;
      CLS_FN: begin
        unique case (funct)
          FN_ADD:  op = ALU_ADD;
          FN_SUB:  op = ALU_SUB;
          FN_AND:  op = ALU_AND;
          FN_OR:   op = ALU_OR;
          FN_XOR:  op = ALU_XOR;
          FN_SLT:  op = ALU_SLT;
          default: fn_known = 1'b0;
        endcase
      end
      default: op = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic            dmem_re,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int IMM_W = 16;
  localparam int JIDX_W = 26;
  localparam int PC_TOP_W = XLEN - JIDX_W - 2;

  // Program counter state
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] jmp_target;

  // Instruction fields
  logic [5:0]           f_opc;
  logic [REG_IDX_W-1:0] f_src_a;
  logic [REG_IDX_W-1:0] f_src_b;
  logic [REG_IDX_W-1:0] f_dst;
  logic [5:0]           f_fn;
  logic [IMM_W-1:0]     f_imm;
  logic [JIDX_W-1:0]    f_jidx;

  ctrl_t           ctl;
  alu_op_e         alu_op;
  logic            fn_known;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] val_a;
  logic [XLEN-1:0] val_b;
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_y;
  logic            alu_zero;
  logic [REG_IDX_W-1:0] wb_idx;
  logic [XLEN-1:0] wb_data;
  logic            wb_en;
  logic            take_branch;

  assign f_opc   = imem_rdata[31:26];
  assign f_src_a = imem_rdata[25:21];
  assign f_src_b = imem_rdata[20:16];
  assign f_dst   = imem_rdata[15:11];
  assign f_fn    = imem_rdata[5:0];
  assign f_imm   = imem_rdata[15:0];
  assign f_jidx  = imem_rdata[25:0];

  sc_main_dec u_main_dec (
    .opcode (f_opc),
    .ctl    (ctl)
  );

  sc_alu_dec u_alu_dec (
    .cls      (ctl.alu_cls),
    .funct    (f_fn),
    .op       (alu_op),
    .fn_known (fn_known)
  );

  sc_regbank #(
    .W (XLEN),
    .N (REG_COUNT)
  ) u_regbank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wb_en),
    .wr_idx    (wb_idx),
    .wr_data   (wb_data),
    .rd_idx_a  (f_src_a),
    .rd_idx_b  (f_src_b),
    .rd_data_a (val_a),
    .rd_data_b (val_b)
  );

  assign imm_ext = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
  assign alu_b   = ctl.b_is_imm ? imm_ext : val_b;

  sc_alu #(
    .W (XLEN)
  ) u_alu (
    .opa     (val_a),
    .opb     (alu_b),
    .op      (alu_op),
    .result  (alu_y),
    .is_zero (alu_zero)
  );

  // Write-back selection
  assign wb_idx  = ctl.dst_is_rd ? f_dst : f_src_b;
  assign wb_data = ctl.wb_from_mem ? dmem_rdata : alu_y;
  assign wb_en   = ctl.reg_we && fn_known;

  // Next-PC logic
  assign pc_plus4    = pc_q + XLEN'(4);
  assign br_target   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_target  = {pc_plus4[XLEN-1 -: PC_TOP_W], f_jidx, 2'b00};
  assign take_branch = ctl.is_branch && alu_zero;

  always_comb begin
    if (ctl.is_jump) begin
      pc_d = jmp_target;
    end else if (take_branch) begin
      pc_d = br_target;
    end else begin
      pc_d = pc_plus4;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = val_b;
  assign dmem_we    = ctl.mem_we;
  assign dmem_re    = ctl.mem_re;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_core_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] imem_addr,
  input logic [XLEN-1:0] imem_rdata,
  input logic            dmem_re,
  input logic            dmem_we
);

  logic [5:0] opc;
  assign opc = imem_rdata[31:26];

  // R1: first cycle after reset release starts at address 0
  p_pc_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (imem_addr == '0));

  // R7: program counter stays word aligned
  p_pc_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[1:0] == 2'b00);

  // R6: non-control-flow instructions advance by one word
  p_seq_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (opc != OPC_BEQ && opc != OPC_JUMP) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

  // R7: jump destination composition
  p_jump_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_JUMP) |=>
      (imem_addr == ((($past(imem_addr) + XLEN'(4)) & 32'hF000_0000) |
                     {4'b0000, $past(imem_rdata[25:0]), 2'b00})));

  // R10: write strobe only for stores
  p_store_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (opc == OPC_STORE));

  // R5: a store never reads
  p_store_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> !dmem_re);

endmodule

bind sc_core sc_core_chk u_chk (.*);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

  logic        clk;
  logic        rst_n;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata;
  logic        dmem_re;
  logic        dmem_we;
  logic [31:0] dmem_addr;
  logic [31:0] dmem_wdata;
  logic [31:0] dmem_rdata;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  // Behavioural reference state
  logic [31:0] m_regs [32];
  logic [31:0] m_dmem [64];
  logic [31:0] m_pc;

  int checks = 0;
  int errs = 0;
  bit done = 0;
  int p = 0;

  sc_core uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_re    (dmem_re),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (rst_n && dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  function automatic logic [31:0] enc_r(input int a, input int b, input int d, input logic [5:0] fn);
    return {6'h00, 5'(a), 5'(b), 5'(d), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int a, input int b, input int imm);
    return {op, 5'(a), 5'(b), 16'(imm)};
  endfunction

  function automatic logic [31:0] enc_j(input int word_idx);
    return {6'h02, 26'(word_idx)};
  endfunction

  task automatic emit(input logic [31:0] w);
    imem[p] = w;
    p++;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [31:0] ins, input logic [31:0] pc);
    logic [5:0] op;
    logic [5:0] fn;
    op = ins[31:26];
    fn = ins[5:0];
    if (op == 6'h00) begin
      if (!(fn inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A})) return "R9";
      if (ins[15:11] == 5'd0) return "R8";
      if (fn == 6'h2A) return "R3";
      return "R2";
    end
    if (op == 6'h23) return "R4";
    if (op == 6'h2B) begin
      if (pc == 32'd0) return "R1";
      if (ins[20:16] == 5'd0) return "R8";
      return "R5";
    end
    if (op == 6'h04) return "R6";
    if (op == 6'h02) return "R7";
    return "R9";
  endfunction

  string prev_tag = "R1";

  // Compare ports with the reference, then advance the reference by one instruction.
  task automatic compare_and_step();
    logic [31:0] ins, a, b, sx, ea, res, pc4;
    logic [5:0] op;
    bit known;
    string t;
    chk(prev_tag, "pc", imem_addr, m_pc);
    ins = imem[m_pc[7:2]];
    op = ins[31:26];
    a = m_regs[ins[25:21]];
    b = m_regs[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]};
    ea = a + sx;
    pc4 = m_pc + 32'd4;
    t = tag_of(ins, m_pc);
    chk((op == 6'h2B) ? t : "R10", "dmem_we", {31'd0, dmem_we}, {31'd0, op == 6'h2B});
    if (op == 6'h2B) begin
      chk(t, "store addr", dmem_addr, ea);
      chk(t, "store data", dmem_wdata, b);
      chk("R5", "store dmem_re", {31'd0, dmem_re}, 32'd0);
      m_dmem[ea[7:2]] = b;
    end
    if (op == 6'h23) begin
      chk("R4", "load addr", dmem_addr, ea);
      chk("R4", "load dmem_re", {31'd0, dmem_re}, 32'd1);
      if (ins[20:16] != 5'd0) m_regs[ins[20:16]] = m_dmem[ea[7:2]];
    end
    if (op == 6'h00) begin
      known = 1;
      res = '0;
      case (ins[5:0])
        6'h20: res = a + b;
        6'h22: res = a - b;
        6'h24: res = a & b;
        6'h25: res = a | b;
        6'h26: res = a ^ b;
        6'h2A: res = {31'd0, (a - b) >> 31 == 32'd1};
        default: known = 0;
      endcase
      if (known && ins[15:11] != 5'd0) m_regs[ins[15:11]] = res;
    end
    if (op == 6'h04 && a == b) m_pc = pc4 + (sx << 2);
    else if (op == 6'h02) m_pc = {pc4[31:28], ins[25:0], 2'b00};
    else m_pc = pc4;
    prev_tag = t;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = enc_j(i);
      dmem[i] = 32'h0101_0101 * i;
    end
    dmem[0] = 32'hF0F0_1234;
    dmem[1] = 32'h0000_5A5A;
    dmem[2] = 32'h0000_0020;
    dmem[3] = 32'h8000_0000;
    dmem[4] = 32'h0000_0001;
    dmem[7] = 32'hCAFE_0007;
    for (int i = 0; i < 64; i++) m_dmem[i] = dmem[i];
    for (int i = 0; i < 32; i++) m_regs[i] = 32'd0;
    m_pc = 32'd0;

    // Program
    emit(enc_i(6'h2B, 0, 13, 124));        // store reset value of r13
    emit(enc_i(6'h23, 0, 1, 0));
    emit(enc_i(6'h23, 0, 2, 4));
    emit(enc_r(1, 2, 3, 6'h20));
    emit(enc_r(1, 2, 4, 6'h22));
    emit(enc_r(1, 2, 5, 6'h24));
    emit(enc_r(1, 2, 6, 6'h25));
    emit(enc_r(1, 2, 7, 6'h26));
    emit(enc_r(1, 2, 8, 6'h2A));
    emit(enc_r(2, 1, 9, 6'h2A));
    emit(enc_i(6'h23, 0, 10, 12));
    emit(enc_i(6'h23, 0, 11, 16));
    emit(enc_r(10, 11, 12, 6'h2A));        // wrapped difference case
    for (int r = 3; r <= 12; r++) emit(enc_i(6'h2B, 0, r, 60 + 4 * r));
    emit(enc_r(1, 2, 0, 6'h20));           // write to r0
    emit(enc_i(6'h2B, 0, 0, 100));
    emit(enc_i(6'h23, 0, 14, 8));
    emit(enc_i(6'h23, 14, 15, -4));        // negative offset
    emit(enc_i(6'h2B, 14, 15, 4));
    emit(32'hFC22_FFFF);                   // unknown opcode
    emit(enc_r(1, 2, 16, 6'h3F));          // unknown function
    emit(enc_i(6'h2B, 0, 16, 104));
    emit(enc_i(6'h04, 1, 1, 2));           // taken
    emit(enc_i(6'h2B, 0, 1, 108));
    emit(enc_i(6'h2B, 0, 2, 108));
    emit(enc_i(6'h04, 1, 2, 1));           // not taken
    emit(enc_i(6'h2B, 0, 3, 112));
    emit(enc_j(p + 2));
    emit(enc_i(6'h2B, 0, 4, 116));
    emit(enc_r(11, 11, 20, 6'h20));
    emit(enc_r(20, 11, 20, 6'h20));
    begin
      int loop_at;
      loop_at = p;
      emit(enc_r(17, 11, 17, 6'h20));
      emit(enc_i(6'h04, 17, 20, 1));
      emit(enc_j(loop_at));
      emit(enc_i(6'h2B, 0, 17, 120));
      emit(enc_j(p));                      // self loop
    end

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "pc in reset", imem_addr, 32'd0);
    rst_n = 1'b1;
    #0.5;
    compare_and_step();
    for (int c = 0; c < 90; c++) begin
      @(negedge clk);
      compare_and_step();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule